// File: doc/BRIEF.md
# Flash Line Buffer Allocator with Sequential Prefetch

This block manages a small set of line buffers that sit in front of a slow flash array. Each cycle it may receive one lookup. A lookup carries a line address, an access type (instruction or data, single or burst), a write flag and the index of the requesting master. The block compares the line address against every buffer tag. It reports a hit or a miss in the same cycle and returns the line of the hitting buffer. When a read misses, the block picks a buffer and raises a fill request to the array. The request stays raised until the array answers with the line data.

Each buffer carries one of six ranked states. The block also keeps a least-recently-used order as a per-buffer age rank. On a miss, the block picks the lowest-numbered empty buffer. When no buffer is empty, it picks the oldest one. A read hit may start a speculative fill of the next sequential line if that line is not already held. This prefetch always goes into the oldest buffer other than the one just hit. A prefetched line does not move in the age order until a later lookup hits it. A set of control inputs gates prefetching. A global enable turns the buffers on and off; while it is clear, all buffers are dropped and every read is reported as a miss.

Top module: `line_buf_alloc`

## Requirements
- R1: After reset no fill is requested and every buffer is empty. The first read then misses and fills buffer 0 with `fill_pf` = 0.
- R2: `lk_hit` is 1 for a valid lookup whose line matches a buffer that is neither empty nor still filling, while `cfg_buf_en` = 1. `lk_miss` = `lk_valid` and not `lk_hit`. `lk_data` is the line of the hitting buffer, and zero when there is no hit.
- R3: A read miss with no fill outstanding fills the lowest-numbered empty buffer, if any buffer is empty.
- R4: When no buffer is empty, a read miss replaces the least-recently-used buffer. After reset the age order, from newest to oldest, is buffer 0 up to buffer NBUF-1. Read hits make a buffer newest.
- R5: A buffer filled for a miss becomes newest in the same cycle that `fill_done` returns its line.
- R6: A read hit on line L starts a prefetch of line L+1 if no buffer that is not empty holds L+1 (`fill_pf` = 1, `fill_line` = L+1). The prefetch goes into the oldest buffer once the hit buffer has been made newest. Completing the prefetch leaves the age order unchanged.
- R7: A prefetched buffer becomes newest when a later read hits it.
- R8: A prefetch starts only if all of these are set: `cfg_buf_en`, a nonzero `cfg_pf_limit`, bit `lk_mst` of `cfg_mst_pf_en`, and `cfg_ipf_en` for instruction reads (`lk_instr` = 1) or `cfg_dpf_en` for data reads.
- R9: A write lookup (`lk_write` = 1) never starts a fill or a prefetch, and it changes no buffer state and no age.
- R10: At most one fill is outstanding. `fill_req`, `fill_line`, `fill_buf` and `fill_pf` hold until the cycle with `fill_done` = 1. A read miss during that time is reported but does not allocate a buffer.
- R11: While `cfg_buf_en` = 0, no lookup hits, no fill starts, and every buffer becomes empty. The buffers stay empty after the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buf_en | input | 1 | Global buffer enable |
| cfg_pf_limit | input | PFL_W | Prefetch limit; any nonzero value allows prefetch |
| cfg_ipf_en | input | 1 | Prefetch enable for instruction reads |
| cfg_dpf_en | input | 1 | Prefetch enable for data reads |
| cfg_mst_pf_en | input | NMST | Per-master prefetch enable |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_line | input | LINE_AW | Line address of the lookup |
| lk_instr | input | 1 | 1 = instruction access, 0 = data access |
| lk_burst | input | 1 | 1 = burst read, 0 = single read |
| lk_write | input | 1 | Lookup is a write |
| lk_mst | input | log2(NMST) | Requesting master index |
| lk_hit | output | 1 | Lookup hits a buffer |
| lk_miss | output | 1 | Lookup misses |
| lk_data | output | LINE_BITS | Line held by the hitting buffer |
| fill_req | output | 1 | Fill request to the array, held until done |
| fill_line | output | LINE_AW | Line address to fetch |
| fill_buf | output | log2(NBUF) | Buffer receiving the fill |
| fill_pf | output | 1 | Fill is a speculative prefetch |
| fill_done | input | 1 | Array returns the line in this cycle |
| fill_data | input | LINE_BITS | Line returned by the array |

## Verification
The hardest case to reach from the ports is a prefetched line that is still the oldest buffer when the next miss arrives. Reaching it takes a read hit with every prefetch gate open, a next line that no buffer holds, and a completed prefetch. It then needs a miss while all buffers are full, and the fill buffer number of that miss is the only place where the unchanged age shows. Directed sequences build this situation with a known age order: first with the prefetched buffer as the next victim, then again after a hit has made it newest. Random traffic over a small pool of adjacent lines then mixes hits, prefetches, outstanding fills and enable drops, and checks them against a cycle model kept in the bench.

// File: rtl/flb_pkg.sv
package flb_pkg;
   // Ranked buffer states; the encoding follows the rank.
   typedef enum logic [2:0] {
      BS_INVALID   = 3'd0,
      BS_USED      = 3'd1,
      BS_VALID     = 3'd2,
      BS_PREF      = 3'd3,
      BS_BUSY_RD   = 3'd4,
      BS_BUSY_FILL = 3'd5
   } bstate_e;
endpackage

// File: rtl/flb_tag_cmp.sv
module flb_tag_cmp #(
   parameter int NBUF = 4,
   parameter int TW   = 20,
   localparam int IW  = $clog2(NBUF)
) (
   input  logic                 en,
   input  logic [TW-1:0]        look_tag,
   input  logic [TW-1:0]        next_tag,
   input  logic [TW-1:0]        tag_q [NBUF],
   input  flb_pkg::bstate_e     st_q  [NBUF],
   output logic [NBUF-1:0]      hit_vec,
   output logic                 hit_any,
   output logic [IW-1:0]        hit_idx,
   output logic                 next_held
);
   import flb_pkg::*;

   logic [NBUF-1:0] held_vec;

   for (genvar g = 0; g < NBUF; g++) begin : g_cmp
      assign hit_vec[g]  = en && (tag_q[g] == look_tag) &&
                           (st_q[g] != BS_INVALID) && (st_q[g] != BS_BUSY_FILL);
      assign held_vec[g] = (tag_q[g] == next_tag) && (st_q[g] != BS_INVALID);
   end

   assign hit_any   = |hit_vec;
   assign next_held = |held_vec;

   always_comb begin
      hit_idx = '0;
      for (int j = 0; j < NBUF; j++)
         if (hit_vec[j]) hit_idx = IW'(j);
   end
endmodule

// File: rtl/flb_pick.sv
module flb_pick #(
   parameter int NBUF = 4,
   localparam int IW  = $clog2(NBUF)
) (
   input  flb_pkg::bstate_e     st_q [NBUF],
   input  logic [IW-1:0]        lru_idx,
   output logic [IW-1:0]        victim
);
   import flb_pkg::*;

   logic [NBUF-1:0] inv_vec;

   for (genvar g = 0; g < NBUF; g++) begin : g_inv
      assign inv_vec[g] = (st_q[g] == BS_INVALID);
   end

   // Lowest-numbered empty buffer wins; otherwise the oldest one.
   always_comb begin
      victim = lru_idx;
      for (int j = NBUF - 1; j >= 0; j--)
         if (inv_vec[j]) victim = IW'(j);
   end
endmodule

// File: rtl/flb_lru.sv
module flb_lru #(
   parameter int NBUF = 4,
   localparam int IW  = $clog2(NBUF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ta_en,
   input  logic [IW-1:0] ta_idx,
   input  logic          tb_en,
   input  logic [IW-1:0] tb_idx,
   input  logic [IW-1:0] excl_idx,
   output logic [IW-1:0] lru_idx,
   output logic [IW-1:0] lru_excl_idx
);
   localparam logic [IW-1:0] OLDEST = IW'(NBUF - 1);
   localparam logic [IW-1:0] SECOND = IW'(NBUF - 2);

   logic [IW-1:0] age_q   [NBUF];
   logic [IW-1:0] age_mid [NBUF];
   logic [IW-1:0] age_d   [NBUF];
   logic [IW-1:0] ref_a, ref_b, excl_tgt;

   // Two ordered touches per cycle: fill completion first, then the hit.
   always_comb begin
      age_mid = age_q;
      ref_a   = age_q[ta_idx];
      if (ta_en) begin
         for (int j = 0; j < NBUF; j++)
            if (age_q[j] < ref_a) age_mid[j] = age_q[j] + 1'b1;
         age_mid[ta_idx] = '0;
      end
      age_d = age_mid;
      ref_b = age_mid[tb_idx];
      if (tb_en) begin
         for (int j = 0; j < NBUF; j++)
            if (age_mid[j] < ref_b) age_d[j] = age_mid[j] + 1'b1;
         age_d[tb_idx] = '0;
      end
   end

   for (genvar g = 0; g < NBUF; g++) begin : g_age
      always_ff @(posedge clk) begin
         if (!rst_n) age_q[g] <= IW'(g);
         else        age_q[g] <= age_d[g];
      end
   end

   always_comb begin
      lru_idx      = '0;
      lru_excl_idx = '0;
      excl_tgt     = (age_q[excl_idx] == OLDEST) ? SECOND : OLDEST;
      for (int j = 0; j < NBUF; j++) begin
         if (age_q[j] == OLDEST)   lru_idx      = IW'(j);
         if (age_q[j] == excl_tgt) lru_excl_idx = IW'(j);
      end
   end

   // R4: the ages always form a permutation of 0..NBUF-1.
   logic [NBUF-1:0] age_seen;
   always_comb begin
      age_seen = '0;
      for (int v = 0; v < NBUF; v++)
         for (int j = 0; j < NBUF; j++)
            if (age_q[j] == IW'(v)) age_seen[v] = 1'b1;
   end

   p_age_perm_r4: assert property (@(posedge clk) disable iff (!rst_n) &age_seen)
      else $error("age ranking lost its permutation");
endmodule

// File: rtl/line_buf_alloc.sv
module line_buf_alloc #(
   parameter int NBUF      = 4,
   parameter int LINE_AW   = 20,
   parameter int LINE_BITS = 128,
   parameter int NMST      = 4,
   parameter int PFL_W     = 3,
   localparam int IW       = $clog2(NBUF),
   localparam int MW       = $clog2(NMST)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_buf_en,
   input  logic [PFL_W-1:0]     cfg_pf_limit,
   input  logic                 cfg_ipf_en,
   input  logic                 cfg_dpf_en,
   input  logic [NMST-1:0]      cfg_mst_pf_en,
   input  logic                 lk_valid,
   input  logic [LINE_AW-1:0]   lk_line,
   input  logic                 lk_instr,
   input  logic                 lk_burst,
   input  logic                 lk_write,
   input  logic [MW-1:0]        lk_mst,
   output logic                 lk_hit,
   output logic                 lk_miss,
   output logic [LINE_BITS-1:0] lk_data,
   output logic                 fill_req,
   output logic [LINE_AW-1:0]   fill_line,
   output logic [IW-1:0]        fill_buf,
   output logic                 fill_pf,
   input  logic                 fill_done,
   input  logic [LINE_BITS-1:0] fill_data
);
   import flb_pkg::*;

   // Elaboration-time parameter checks
   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0) begin : g_bad_nbuf
      $error("NBUF must be a power of two of at least 2");
   end
   if (NMST < 2 || (NMST & (NMST - 1)) != 0) begin : g_bad_nmst
      $error("NMST must be a power of two of at least 2");
   end
   if (LINE_BITS < 8 || (LINE_BITS % 8) != 0) begin : g_bad_line
      $error("LINE_BITS must be a whole number of bytes");
   end
   if (LINE_AW < 2 || PFL_W < 1) begin : g_bad_widths
      $error("LINE_AW and PFL_W too small");
   end

   bstate_e              st_q   [NBUF];
   logic [LINE_AW-1:0]   tag_q  [NBUF];
   logic [LINE_BITS-1:0] data_q [NBUF];

   logic                 fill_req_q, fill_pf_q, pend_burst_q;
   logic [LINE_AW-1:0]   fill_line_q;
   logic [IW-1:0]        fill_buf_q;

   logic [LINE_AW-1:0]   next_line;
   logic [NBUF-1:0]      hit_vec;
   logic                 hit_any, next_held;
   logic [IW-1:0]        hit_idx, lru_idx, lru_excl_idx, miss_victim;

   assign next_line = lk_line + 1'b1;

   flb_tag_cmp #(.NBUF(NBUF), .TW(LINE_AW)) u_cmp (
      .en        (cfg_buf_en),
      .look_tag  (lk_line),
      .next_tag  (next_line),
      .tag_q     (tag_q),
      .st_q      (st_q),
      .hit_vec   (hit_vec),
      .hit_any   (hit_any),
      .hit_idx   (hit_idx),
      .next_held (next_held)
   );

   // Access decode and gating
   logic rd_ok, rd_hit, type_pf_en, pf_go, miss_go, done_go, loaded, loaded_miss;

   assign lk_hit     = lk_valid && hit_any;
   assign lk_miss    = lk_valid && !hit_any;
   assign lk_data    = lk_hit ? data_q[hit_idx] : '0;

   assign rd_ok      = lk_valid && !lk_write;
   assign rd_hit     = rd_ok && hit_any;
   assign type_pf_en = lk_instr ? cfg_ipf_en : cfg_dpf_en;
   assign pf_go      = rd_hit && cfg_buf_en && (|cfg_pf_limit) && cfg_mst_pf_en[lk_mst] &&
                       type_pf_en && !fill_req_q && !next_held;
   assign miss_go    = rd_ok && !hit_any && cfg_buf_en && !fill_req_q;
   assign done_go    = fill_req_q && fill_done;
   assign loaded     = done_go && cfg_buf_en && (st_q[fill_buf_q] == BS_BUSY_FILL);
   assign loaded_miss = loaded && !fill_pf_q;

   flb_lru #(.NBUF(NBUF)) u_lru (
      .clk          (clk),
      .rst_n        (rst_n),
      .ta_en        (loaded_miss),
      .ta_idx       (fill_buf_q),
      .tb_en        (rd_hit),
      .tb_idx       (hit_idx),
      .excl_idx     (hit_idx),
      .lru_idx      (lru_idx),
      .lru_excl_idx (lru_excl_idx)
   );

   flb_pick #(.NBUF(NBUF)) u_pick (
      .st_q    (st_q),
      .lru_idx (lru_idx),
      .victim  (miss_victim)
   );

   logic [IW-1:0]      alloc_idx;
   logic [LINE_AW-1:0] alloc_line;
   logic               alloc_go;

   assign alloc_go   = pf_go || miss_go;
   assign alloc_idx  = pf_go ? lru_excl_idx : miss_victim;
   assign alloc_line = pf_go ? next_line : lk_line;

   // Per-buffer state, tag and data
   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      logic done_here, alloc_here, hit_here;
      assign done_here  = loaded && (fill_buf_q == IW'(g));
      assign alloc_here = alloc_go && (alloc_idx == IW'(g));
      assign hit_here   = rd_hit && (hit_idx == IW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]  <= BS_INVALID;
            tag_q[g] <= '0;
         end else if (!cfg_buf_en) begin
            st_q[g]  <= BS_INVALID;
         end else if (done_here) begin
            if (fill_pf_q)         st_q[g] <= BS_PREF;
            else if (pend_burst_q) st_q[g] <= BS_USED;
            else                   st_q[g] <= BS_VALID;
         end else if (alloc_here) begin
            st_q[g]  <= BS_BUSY_FILL;
            tag_q[g] <= alloc_line;
         end else if (hit_here) begin
            st_q[g]  <= lk_burst ? BS_BUSY_RD : BS_VALID;
         end else if (st_q[g] == BS_BUSY_RD) begin
            st_q[g]  <= BS_USED;
         end
      end

      always_ff @(posedge clk) begin
         if (done_here) data_q[g] <= fill_data;
      end
   end

   // Single outstanding fill request
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_req_q   <= 1'b0;
         fill_pf_q    <= 1'b0;
         pend_burst_q <= 1'b0;
         fill_line_q  <= '0;
         fill_buf_q   <= '0;
      end else if (done_go) begin
         fill_req_q   <= 1'b0;
      end else if (alloc_go) begin
         fill_req_q   <= 1'b1;
         fill_pf_q    <= pf_go;
         pend_burst_q <= lk_burst;
         fill_line_q  <= alloc_line;
         fill_buf_q   <= alloc_idx;
      end
   end

   assign fill_req  = fill_req_q;
   assign fill_line = fill_line_q;
   assign fill_buf  = fill_buf_q;
   assign fill_pf   = fill_pf_q;

   // Assertions
   logic [NBUF-1:0] filling_vec;
   for (genvar g = 0; g < NBUF; g++) begin : g_fv
      assign filling_vec[g] = (st_q[g] == BS_BUSY_FILL);
   end

   p_hit_single_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec))
      else $error("more than one buffer hit");

   p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req && !fill_done |=> fill_req && $stable(fill_line) && $stable(fill_buf) && $stable(fill_pf))
      else $error("fill request changed before completion");

   p_one_filling_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(filling_vec) <= 1)
      else $error("more than one buffer filling");

   p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_write && !fill_req |=> !fill_req)
      else $error("write started a fill");

   p_off_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_buf_en |-> !lk_hit)
      else $error("hit while buffers disabled");

   p_pf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_req) && fill_pf |-> $past(|cfg_pf_limit) && $past(cfg_buf_en) && $past(lk_hit))
      else $error("prefetch started without its gates");
endmodule

// File: tb/line_buf_alloc_tb_top.sv
module line_buf_alloc_tb_top;
   localparam int NB = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_buf_en, cfg_ipf_en, cfg_dpf_en;
   logic [2:0]   cfg_pf_limit;
   logic [3:0]   cfg_mst_pf_en;
   logic         lk_valid, lk_instr, lk_burst, lk_write;
   logic [19:0]  lk_line;
   logic [1:0]   lk_mst;
   logic         lk_hit, lk_miss;
   logic [127:0] lk_data;
   logic         fill_req, fill_pf, fill_done;
   logic [19:0]  fill_line;
   logic [1:0]   fill_buf;
   logic [127:0] fill_data;

   always #4 clk = ~clk;   // 125 MHz

   function automatic logic [127:0] line_data(logic [19:0] t);
      return {32'(t) ^ 32'h1357_0000, 32'(t) ^ 32'h2468_0000,
              32'(t) ^ 32'hA5A5_0000, 32'(t) ^ 32'h0F0F_0000};
   endfunction

   assign fill_data = line_data(fill_line);

   line_buf_alloc dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_buf_en(cfg_buf_en), .cfg_pf_limit(cfg_pf_limit),
      .cfg_ipf_en(cfg_ipf_en), .cfg_dpf_en(cfg_dpf_en), .cfg_mst_pf_en(cfg_mst_pf_en),
      .lk_valid(lk_valid), .lk_line(lk_line), .lk_instr(lk_instr), .lk_burst(lk_burst),
      .lk_write(lk_write), .lk_mst(lk_mst), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_data(lk_data), .fill_req(fill_req), .fill_line(fill_line), .fill_buf(fill_buf),
      .fill_pf(fill_pf), .fill_done(fill_done), .fill_data(fill_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Bench model: 0 empty, 1 filling, 2 holding a line
   int          m_st  [NB];
   int          m_age [NB];
   logic [19:0] m_tag [NB];
   bit          m_freq, m_fpf;
   int          m_fbuf;
   logic [19:0] m_fline;

   task automatic m_touch(int k);
      int r = m_age[k];
      for (int j = 0; j < NB; j++) if (m_age[j] < r) m_age[j]++;
      m_age[k] = 0;
   endtask

   function automatic int m_oldest();
      int o = 0;
      for (int j = 0; j < NB; j++) if (m_age[j] == NB - 1) o = j;
      return o;
   endfunction

   task automatic m_reset();
      for (int j = 0; j < NB; j++) begin m_st[j] = 0; m_age[j] = j; m_tag[j] = '0; end
      m_freq = 0; m_fpf = 0; m_fbuf = 0; m_fline = '0;
   endtask

   // Check outputs against the model, then advance the model across one edge.
   task automatic step();
      int hi = -1;
      bit hit, busy, rd, pfok, held;
      logic [19:0] nt;
      int v;
      #2;
      if (cfg_buf_en) for (int j = 0; j < NB; j++)
         if (m_st[j] == 2 && m_tag[j] == lk_line) hi = j;
      hit = lk_valid && hi >= 0;
      chk("R2 hit", 128'(lk_hit), 128'(hit));
      chk("R2 miss", 128'(lk_miss), 128'(lk_valid && !hit));
      chk("R2 data", lk_data, hit ? line_data(lk_line) : 128'd0);
      chk("R10 fill_req", 128'(fill_req), 128'(m_freq));
      if (m_freq) begin
         chk("R4 fill_buf", 128'(fill_buf), 128'(m_fbuf));
         chk("R6 fill_line", 128'(fill_line), 128'(m_fline));
         chk("R6 fill_pf", 128'(fill_pf), 128'(m_fpf));
      end
      busy = m_freq;
      rd   = lk_valid && !lk_write;
      nt   = lk_line + 20'd1;
      held = 0;
      for (int j = 0; j < NB; j++) if (m_st[j] != 0 && m_tag[j] == nt) held = 1;
      if (busy && fill_done) begin
         if (cfg_buf_en && m_st[m_fbuf] == 1) begin
            m_st[m_fbuf] = 2;
            if (!m_fpf) m_touch(m_fbuf);
         end
         m_freq = 0;
      end
      pfok = rd && hit && cfg_buf_en && cfg_pf_limit != 0 && cfg_mst_pf_en[lk_mst] &&
             (lk_instr ? cfg_ipf_en : cfg_dpf_en) && !busy && !held;
      if (rd && hit) m_touch(hi);
      if (pfok) begin
         v = m_oldest();
         m_st[v] = 1; m_tag[v] = nt;
         m_freq = 1; m_fbuf = v; m_fline = nt; m_fpf = 1;
      end else if (rd && !hit && cfg_buf_en && !busy) begin
         v = -1;
         for (int j = NB - 1; j >= 0; j--) if (m_st[j] == 0) v = j;
         if (v < 0) v = m_oldest();
         m_st[v] = 1; m_tag[v] = lk_line;
         m_freq = 1; m_fbuf = v; m_fline = lk_line; m_fpf = 0;
      end
      if (!cfg_buf_en) for (int j = 0; j < NB; j++) m_st[j] = 0;
      @(posedge clk);
      #1;
   endtask

   task automatic rd(logic [19:0] line, bit instr, bit burst);
      lk_valid = 1; lk_write = 0; lk_line = line; lk_instr = instr; lk_burst = burst;
      step();
      lk_valid = 0;
   endtask

   task automatic complete();
      fill_done = 1; lk_valid = 0;
      step();
      fill_done = 0;
   endtask

   task automatic idle_in();
      lk_valid = 0; lk_write = 0; lk_line = '0; lk_instr = 0; lk_burst = 0; lk_mst = 0;
      fill_done = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      idle_in();
      cfg_buf_en = 1; cfg_pf_limit = 0; cfg_ipf_en = 1; cfg_dpf_en = 1; cfg_mst_pf_en = 4'hF;
      rst_n = 0;
      m_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state and first fill
      #1 chk("R1 reset fill_req", 128'(fill_req), 128'd0);
      #1 chk("R1 reset lookup hit", 128'(lk_hit), 128'd0);
      rd(20'h100, 0, 0);
      chk("R1 first fill buf", 128'(fill_buf), 128'd0);
      chk("R1 first fill pf", 128'(fill_pf), 128'd0);
      complete();

      // R3: empty buffers fill in index order
      rd(20'h200, 0, 0); chk("R3 fill buf1", 128'(fill_buf), 128'd1); complete();
      rd(20'h300, 0, 1); chk("R3 fill buf2", 128'(fill_buf), 128'd2); complete();
      rd(20'h400, 1, 0); chk("R3 fill buf3", 128'(fill_buf), 128'd3); complete();

      // R4 / R5: LRU replacement, miss fill becomes newest
      rd(20'h100, 0, 1);
      rd(20'h500, 0, 0); chk("R4 lru victim", 128'(fill_buf), 128'd1); complete();
      rd(20'h600, 0, 0); chk("R5 miss fill newest", 128'(fill_buf), 128'd2); complete();

      // R6: prefetch into oldest, recency untouched
      cfg_pf_limit = 3'd1;
      rd(20'h100, 1, 0);
      chk("R6 pf flag", 128'(fill_pf), 128'd1);
      chk("R6 pf line", 128'(fill_line), 128'h101);
      chk("R6 pf buf", 128'(fill_buf), 128'd3);
      complete();
      cfg_pf_limit = 3'd0;
      rd(20'h700, 0, 0); chk("R6 pf kept oldest", 128'(fill_buf), 128'd3); complete();

      // R7: hit on prefetched buffer makes it newest
      cfg_pf_limit = 3'd2;
      rd(20'h600, 0, 0);
      chk("R7 pf buf", 128'(fill_buf), 128'd1);
      complete();
      cfg_pf_limit = 3'd0;
      lk_valid = 1; lk_line = 20'h601; lk_write = 0; #1;
      chk("R7 hit on prefetched", 128'(lk_hit), 128'd1);
      rd(20'h601, 0, 0);
      rd(20'h800, 0, 0); chk("R7 victim after pf hit", 128'(fill_buf), 128'd0); complete();

      // R8: each prefetch gate blocks on its own
      cfg_pf_limit = 3'd0; rd(20'h700, 0, 0);
      chk("R8 limit zero", 128'(fill_req), 128'd0);
      cfg_pf_limit = 3'd1; cfg_mst_pf_en = 4'b1101; lk_mst = 2'd1; rd(20'h700, 0, 0);
      chk("R8 master off", 128'(fill_req), 128'd0);
      cfg_mst_pf_en = 4'hF; cfg_ipf_en = 0; rd(20'h700, 1, 0);
      chk("R8 instr off", 128'(fill_req), 128'd0);
      cfg_ipf_en = 1; cfg_dpf_en = 0; rd(20'h700, 0, 0);
      chk("R8 data off", 128'(fill_req), 128'd0);
      cfg_dpf_en = 1; rd(20'h600, 0, 0);
      chk("R6 next held", 128'(fill_req), 128'd0);
      rd(20'h700, 0, 0);
      chk("R8 all open", 128'(fill_req), 128'd1);
      chk("R8 pf line", 128'(fill_line), 128'h701);
      complete();
      lk_mst = 2'd0;

      // R9: writes neither fill nor prefetch
      lk_valid = 1; lk_write = 1; lk_line = 20'h900; step();
      chk("R9 write miss no fill", 128'(fill_req), 128'd0);
      lk_line = 20'h800; #1;
      chk("R9 write hit", 128'(lk_hit), 128'd1);
      step();
      chk("R9 write hit no pf", 128'(fill_req), 128'd0);
      lk_valid = 0; lk_write = 0;

      // R10: miss during outstanding fill
      cfg_pf_limit = 3'd0;
      rd(20'hA00, 0, 0);
      lk_valid = 1; lk_line = 20'hB00; #1;
      chk("R10 miss while busy", 128'(lk_miss), 128'd1);
      step(); lk_valid = 0;
      chk("R10 fill kept", 128'(fill_line), 128'hA00);
      complete();

      // R11: disable drops all buffers
      cfg_buf_en = 0;
      lk_valid = 1; lk_line = 20'hA00; #1;
      chk("R11 no hit when off", 128'(lk_hit), 128'd0);
      chk("R11 miss when off", 128'(lk_miss), 128'd1);
      step(); lk_valid = 0;
      chk("R11 no fill when off", 128'(fill_req), 128'd0);
      cfg_buf_en = 1;
      lk_valid = 1; lk_line = 20'hA00; #1;
      chk("R11 invalidated", 128'(lk_hit), 128'd0);
      step(); lk_valid = 0;
      chk("R11 refill lowest", 128'(fill_buf), 128'd0);
      complete();

      // Random phase
      for (int c = 0; c < 5000; c++) begin
         if (c % 40 == 0) begin
            cfg_buf_en    = ($urandom % 12) != 0;
            cfg_pf_limit  = 3'($urandom % 4);
            cfg_ipf_en    = 1'($urandom);
            cfg_dpf_en    = 1'($urandom);
            cfg_mst_pf_en = 4'($urandom);
         end
         lk_valid  = ($urandom % 5) != 0;
         lk_write  = ($urandom % 10) == 0;
         lk_line   = 20'h40 + 20'($urandom % 12);
         lk_instr  = 1'($urandom);
         lk_burst  = 1'($urandom);
         lk_mst    = 2'($urandom);
         fill_done = ($urandom % 3) == 0;
         step();
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule